// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block decides which interrupt an 8-bit processor takes next and when it takes it. Each maskable source has a 2-bit software level. A source is taken only when its level is strictly above the level the processor is running at, so a handler can be interrupted by more urgent work and by nothing else. When several sources qualify, the highest level wins. Among sources at the same level, the fixed hardware order decides, with lower index winning. Three sources sit outside the programmable levels. The software trap cannot be masked. The top-level event can be masked, but only by the fully-masked level, and it beats every programmable source. Reset is handled at start-up.

Requests are only considered at an instruction boundary. Once a source is accepted, the block asks the processor to push its context and waits for the acknowledge. It then issues the vector address and the level to load into the two level bits of the condition code. On a return from interrupt, the block asks for the context to be popped and reloads the level bits from the popped condition code. The stack and the datapath are outside the block; they are reached only through this request/acknowledge pair.

Top module: `irqn_nest_ctrl`

## Requirements
- R1: While reset is low, and up to the first clock edge after it is released, svc_valid=1, lvl_load=1, svc_addr=16'hFFFE, lvl_new=2'b11, and both context requests are 0. When svc_valid is 0, svc_addr reads 0. When lvl_load is 0, lvl_new reads 0.
- R2: Requests are accepted only at a rising edge where the block is idle and instr_done=1. Requests present at other edges start nothing. ctx_ack received while no context request is open has no effect.
- R3: Levels use the I1:I0 encoding: 2'b10=level 0, 2'b01=level 1, 2'b00=level 2, 2'b11=level 3. The current level is read from cpu_lvl in the same encoding. A maskable source i (irq_req[i], field irq_prio[2i+1:2i]) is eligible only if its level is strictly greater than the current level.
- R4: Among eligible maskable sources, the highest level wins. Among sources at equal level, the lowest index wins. Source i has vector address 16'hFFF8 - 2*i.
- R5: trap_req is never masked. It beats every other request, uses vector 16'hFFFC and loads level bits 2'b11.
- R6: tli_req is taken whenever cpu_lvl is not 2'b11. It beats all maskable sources, uses vector 16'hFFFA and loads 2'b11.
- R7: The cycle after acceptance, ctx_save_req=1. It stays 1 until an edge where ctx_ack=1. In the cycle after that edge, svc_valid=1 and lvl_load=1 for exactly one cycle. svc_addr is then the winner's vector, and lvl_new is the winner's field (2'b11 for trap and top-level).
- R8: The winner and its level are captured at acceptance. Changes to requests, fields or cpu_lvl during the save handshake do not alter the vector or level issued.
- R9: iret_req at an idle edge starts a return, and takes precedence over instr_done at the same edge. ctx_restore_req=1 from the next cycle until an edge with ctx_ack=1. In the cycle after that edge, lvl_load=1, svc_valid=0 and lvl_new = {popped_cc[5], popped_cc[3]}.
- R10: A field of 2'b11 ranks as level 3. Such a source is taken at any current level except 2'b11, and it beats a source at level 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | NUM_SRC | Pending lines of the maskable sources |
| irq_prio | input | 2*NUM_SRC | Per-source 2-bit level field, source i at bits 2i+1:2i |
| tli_req | input | 1 | Top-level maskable event |
| trap_req | input | 1 | Software trap, non-maskable |
| cpu_lvl | input | 2 | Current I1:I0 level bits |
| instr_done | input | 1 | Instruction boundary strobe |
| iret_req | input | 1 | Return-from-interrupt request |
| ctx_ack | input | 1 | Push/pop handshake acknowledge |
| popped_cc | input | 8 | Condition code restored by the pop |
| svc_valid | output | 1 | Vector issued this cycle |
| svc_addr | output | 16 | Vector address |
| lvl_new | output | 2 | Level bits to load |
| lvl_load | output | 1 | Load lvl_new into the condition code |
| ctx_save_req | output | 1 | Request to push the context |
| ctx_restore_req | output | 1 | Request to pop the context |

## Verification
All outputs come from registered state only. An acceptance at edge N therefore shows ctx_save_req in the cycle after edge N. The vector and level appear in the cycle after the edge that samples ctx_ack, and a return's level reload follows the same one-cycle-after-acknowledge rule. The bench drives inputs and samples outputs on the falling edge. A behavioural model steps on the rising edge, so its expected outputs line up with the same register count as the design. It is compared with the design on every cycle. Directed sequences add point checks at the exact cycle where each grant, reload or absent request is due, with acknowledge delays of zero, one and several cycles.

// File: rtl/irqn_pkg.sv
package irqn_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_SAVE,
    ST_GRANT,
    ST_RESTORE,
    ST_RLOAD
  } seq_state_t;

  typedef enum logic [1:0] {
    WIN_NONE,
    WIN_TRAP,
    WIN_TLI,
    WIN_SRC
  } win_kind_t;

  localparam logic [15:0] RESET_ADDR = 16'hFFFE;
  localparam logic [15:0] TRAP_ADDR  = 16'hFFFC;
  localparam logic [15:0] TLI_ADDR   = 16'hFFFA;
  localparam logic [15:0] SRC_BASE   = 16'hFFF8;
  localparam int          CC_I1_BIT  = 5;
  localparam int          CC_I0_BIT  = 3;

  // I1:I0 field to a numeric rank (0 lowest .. 3 fully masked)
  function automatic logic [1:0] field_to_rank(input logic [1:0] f);
    case (f)
      2'b10:   return 2'd0;
      2'b01:   return 2'd1;
      2'b00:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [1:0] rank_to_field(input logic [1:0] r);
    case (r)
      2'd0:    return 2'b10;
      2'd1:    return 2'b01;
      2'd2:    return 2'b00;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [15:0] src_vec_addr(input logic [7:0] idx);
    return SRC_BASE - ({8'd0, idx} << 1);
  endfunction

endpackage

// File: rtl/irqn_eligibility.sv
module irqn_eligibility
  import irqn_pkg::*;
#(
  parameter int NUM_SRC = 13
) (
  input  logic [NUM_SRC-1:0]   irq_req,
  input  logic [2*NUM_SRC-1:0] irq_prio,
  input  logic [1:0]           cur_rank,
  output logic [NUM_SRC-1:0]   elig,
  output logic [2*NUM_SRC-1:0] src_rank_flat
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [1:0] rank_g;
    assign rank_g                   = field_to_rank(irq_prio[2*g +: 2]);
    assign src_rank_flat[2*g +: 2]  = rank_g;
    assign elig[g]                  = irq_req[g] && (rank_g > cur_rank);
  end

endmodule

// File: rtl/irqn_arbiter.sv
module irqn_arbiter
  import irqn_pkg::*;
#(
  parameter int NUM_SRC = 13,
  parameter int IDX_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   elig,
  input  logic [2*NUM_SRC-1:0] src_rank_flat,
  input  logic [1:0]           cur_rank,
  input  logic                 trap_req,
  input  logic                 tli_req,
  output win_kind_t            win_kind,
  output logic [IDX_W-1:0]     win_idx,
  output logic [1:0]           win_rank
);

  logic             src_found;
  logic [1:0]       best_rank;
  logic [IDX_W-1:0] best_idx;

  // highest rank first; strict compare keeps the lowest index on ties
  always_comb begin
    src_found = 1'b0;
    best_rank = 2'd0;
    best_idx  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!src_found || (src_rank_flat[2*i +: 2] > best_rank))) begin
        src_found = 1'b1;
        best_rank = src_rank_flat[2*i +: 2];
        best_idx  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    win_kind = WIN_NONE;
    win_idx  = '0;
    win_rank = 2'd3;
    if (trap_req) begin
      win_kind = WIN_TRAP;
    end else if (tli_req && (cur_rank != 2'd3)) begin
      win_kind = WIN_TLI;
    end else if (src_found) begin
      win_kind = WIN_SRC;
      win_idx  = best_idx;
      win_rank = best_rank;
    end
  end

  // R3
  src_rank_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_kind == WIN_SRC) |-> (win_rank > cur_rank));

  // R5
  trap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (win_kind == WIN_TRAP));

  // R6
  tli_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_kind == WIN_TLI) |-> (cur_rank != 2'd3));

endmodule

// File: rtl/irqn_sequencer.sv
module irqn_sequencer
  import irqn_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  win_kind_t        win_kind,
  input  logic [IDX_W-1:0] win_idx,
  input  logic [1:0]       win_rank,
  input  logic             instr_done,
  input  logic             iret_req,
  input  logic             ctx_ack,
  input  logic [7:0]       popped_cc,
  output logic             svc_valid,
  output logic [15:0]      svc_addr,
  output logic [1:0]       lvl_new,
  output logic             lvl_load,
  output logic             ctx_save_req,
  output logic             ctx_restore_req
);

  seq_state_t  state;
  logic [15:0] held_addr;
  logic [1:0]  held_lvl;
  logic [15:0] grant_addr;
  logic [1:0]  popped_lvl;
  logic        accept;
  logic        start_ret;
  logic        unused_cc_bits;

  assign popped_lvl     = {popped_cc[CC_I1_BIT], popped_cc[CC_I0_BIT]};
  assign unused_cc_bits = ^{popped_cc[7:6], popped_cc[4], popped_cc[2:0]};

  always_comb begin
    case (win_kind)
      WIN_TRAP: grant_addr = TRAP_ADDR;
      WIN_TLI:  grant_addr = TLI_ADDR;
      WIN_SRC:  grant_addr = src_vec_addr(8'(win_idx));
      default:  grant_addr = 16'h0000;
    endcase
  end

  assign start_ret = (state == ST_IDLE) && iret_req;
  assign accept    = (state == ST_IDLE) && !iret_req && instr_done && (win_kind != WIN_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_BOOT;
      held_addr <= '0;
      held_lvl  <= '0;
    end else begin
      case (state)
        ST_BOOT: state <= ST_IDLE;
        ST_IDLE: begin
          if (start_ret) begin
            state <= ST_RESTORE;
          end else if (accept) begin
            state     <= ST_SAVE;
            held_addr <= grant_addr;
            held_lvl  <= rank_to_field(win_rank);
          end
        end
        ST_SAVE:    if (ctx_ack) state <= ST_GRANT;
        ST_GRANT:   state <= ST_IDLE;
        ST_RESTORE: begin
          if (ctx_ack) begin
            state    <= ST_RLOAD;
            held_lvl <= popped_lvl;
          end
        end
        ST_RLOAD: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    svc_valid       = (state == ST_BOOT) || (state == ST_GRANT);
    lvl_load        = svc_valid || (state == ST_RLOAD);
    ctx_save_req    = (state == ST_SAVE);
    ctx_restore_req = (state == ST_RESTORE);
    svc_addr        = (state == ST_BOOT)  ? RESET_ADDR :
                      (state == ST_GRANT) ? held_addr  : 16'h0000;
    lvl_new         = (state == ST_BOOT) ? 2'b11 :
                      lvl_load           ? held_lvl : 2'b00;
  end

  // R7
  save_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_save_req && !ctx_ack) |=> ctx_save_req);

  // R7
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |=> !svc_valid);

  // R9
  restore_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_load && !svc_valid) |-> (lvl_new == $past({popped_cc[5], popped_cc[3]})));

  // R9
  ctx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctx_save_req && ctx_restore_req));

endmodule

// File: rtl/irqn_nest_ctrl.sv
module irqn_nest_ctrl
  import irqn_pkg::*;
#(
  parameter int NUM_SRC = 13,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   irq_req,
  input  logic [2*NUM_SRC-1:0] irq_prio,
  input  logic                 tli_req,
  input  logic                 trap_req,
  input  logic [1:0]           cpu_lvl,
  input  logic                 instr_done,
  input  logic                 iret_req,
  input  logic                 ctx_ack,
  input  logic [7:0]           popped_cc,
  output logic                 svc_valid,
  output logic [15:0]          svc_addr,
  output logic [1:0]           lvl_new,
  output logic                 lvl_load,
  output logic                 ctx_save_req,
  output logic                 ctx_restore_req
);

  logic [1:0]           cur_rank;
  logic [NUM_SRC-1:0]   elig;
  logic [2*NUM_SRC-1:0] src_rank_flat;
  win_kind_t            win_kind;
  logic [IDX_W-1:0]     win_idx;
  logic [1:0]           win_rank;

  assign cur_rank = field_to_rank(cpu_lvl);

  irqn_eligibility #(.NUM_SRC(NUM_SRC)) u_elig (
    .irq_req       (irq_req),
    .irq_prio      (irq_prio),
    .cur_rank      (cur_rank),
    .elig          (elig),
    .src_rank_flat (src_rank_flat)
  );

  irqn_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .clk           (clk),
    .rst_n         (rst_n),
    .elig          (elig),
    .src_rank_flat (src_rank_flat),
    .cur_rank      (cur_rank),
    .trap_req      (trap_req),
    .tli_req       (tli_req),
    .win_kind      (win_kind),
    .win_idx       (win_idx),
    .win_rank      (win_rank)
  );

  irqn_sequencer #(.IDX_W(IDX_W)) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .win_kind        (win_kind),
    .win_idx         (win_idx),
    .win_rank        (win_rank),
    .instr_done      (instr_done),
    .iret_req        (iret_req),
    .ctx_ack         (ctx_ack),
    .popped_cc       (popped_cc),
    .svc_valid       (svc_valid),
    .svc_addr        (svc_addr),
    .lvl_new         (lvl_new),
    .lvl_load        (lvl_load),
    .ctx_save_req    (ctx_save_req),
    .ctx_restore_req (ctx_restore_req)
  );

  // R7
  grant_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && (svc_addr != RESET_ADDR)) |-> $past(ctx_save_req && ctx_ack));

endmodule

// File: tb/tb_irqn_nest_ctrl.sv
module tb_irqn_nest_ctrl;

  localparam int NS = 13;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NS-1:0]   irq_req;
  logic [2*NS-1:0] irq_prio;
  logic            tli_req, trap_req, instr_done, iret_req, ctx_ack;
  logic [1:0]      cpu_lvl;
  logic [7:0]      popped_cc;
  logic            svc_valid, lvl_load, ctx_save_req, ctx_restore_req;
  logic [15:0]     svc_addr;
  logic [1:0]      lvl_new;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    done   = 0;
  string cur_tag = "R1";

  // reference model state
  int          phase = 0;  // 0 boot,1 idle,2 saving,3 granting,4 restoring,5 reloading
  logic [15:0] m_addr = '0;
  logic [1:0]  m_lvl  = '0;

  always #5 clk = ~clk;

  irqn_nest_ctrl #(.NUM_SRC(NS)) dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_prio(irq_prio),
    .tli_req(tli_req), .trap_req(trap_req), .cpu_lvl(cpu_lvl),
    .instr_done(instr_done), .iret_req(iret_req), .ctx_ack(ctx_ack),
    .popped_cc(popped_cc), .svc_valid(svc_valid), .svc_addr(svc_addr),
    .lvl_new(lvl_new), .lvl_load(lvl_load), .ctx_save_req(ctx_save_req),
    .ctx_restore_req(ctx_restore_req)
  );

  function automatic int lvl_num(input logic [1:0] f);
    return (f == 2'b10) ? 0 : (f == 2'b01) ? 1 : (f == 2'b00) ? 2 : 3;
  endfunction

  function automatic void pick(output bit found, output logic [15:0] a, output logic [1:0] l);
    int cur;
    cur = lvl_num(cpu_lvl);
    found = 0; a = '0; l = '0;
    if (trap_req) begin found = 1; a = 16'hFFFC; l = 2'b11; return; end
    if (tli_req && cur < 3) begin found = 1; a = 16'hFFFA; l = 2'b11; return; end
    for (int lv = 3; lv > cur; lv--)
      for (int i = 0; i < NS; i++)
        if (!found && irq_req[i] && lvl_num(irq_prio[2*i +: 2]) == lv) begin
          found = 1; a = 16'hFFF8 - 16'(2*i); l = irq_prio[2*i +: 2];
        end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase = 0;
    else begin
      case (phase)
        0: phase = 1;
        1: begin
          if (iret_req) phase = 4;
          else if (instr_done) begin
            bit f; logic [15:0] a; logic [1:0] l;
            pick(f, a, l);
            if (f) begin phase = 2; m_addr = a; m_lvl = l; end
          end
        end
        2: if (ctx_ack) phase = 3;
        3: phase = 1;
        4: if (ctx_ack) begin m_lvl = {popped_cc[5], popped_cc[3]}; phase = 5; end
        default: phase = 1;
      endcase
    end
  end

  function automatic string phase_tag(input int p);
    case (p)
      0: return "R1";
      2, 3: return "R7";
      4, 5: return "R9";
      default: return "R2";
    endcase
  endfunction

  // cycle compare against the model
  always @(negedge clk) begin
    if (!done) begin
      logic [22:0] act, exp;
      bit          ev, el;
      ev  = (phase == 0) || (phase == 3);
      el  = ev || (phase == 5);
      exp = {ev, el, (phase == 2), (phase == 4),
             (phase == 0) ? 2'b11 : (el ? m_lvl : 2'b00),
             (phase == 0) ? 16'hFFFE : ((phase == 3) ? m_addr : 16'h0000)};
      act = {svc_valid, lvl_load, ctx_save_req, ctx_restore_req, lvl_new, svc_addr};
      checks++;
      if (act !== exp) begin
        fails++;
        $display("FAIL %s model compare at cycle %0d: actual=%h expected=%h",
                 (cur_tag == "RND") ? phase_tag(phase) : cur_tag, cyc, act, exp);
      end
    end
  end

  task automatic report();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL R2 watchdog expired: actual=running expected=finished");
      report();
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s point check: actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic set_prio(input int i, input logic [1:0] f);
    irq_prio[2*i +: 2] = f;
  endtask

  task automatic clear_reqs();
    irq_req = '0; tli_req = 0; trap_req = 0;
  endtask

  // accept at next edge, ack after waitc cycles, check the grant
  task automatic do_entry(input int waitc, input logic [15:0] ea, input logic [1:0] el, input string t);
    cur_tag = t;
    instr_done = 1;
    @(negedge clk);
    instr_done = 0;
    chk(t, {31'd0, ctx_save_req}, 32'd1);
    repeat (waitc) @(negedge clk);
    ctx_ack = 1;
    @(negedge clk);
    ctx_ack = 0;
    chk(t, {12'd0, svc_valid, lvl_load, lvl_new, svc_addr}, {12'd0, 1'b1, 1'b1, el, ea});
    @(negedge clk);
  endtask

  task automatic do_return(input logic [7:0] cc, input int waitc, input logic [1:0] el);
    cur_tag = "R9";
    iret_req = 1;
    @(negedge clk);
    iret_req = 0;
    chk("R9", {30'd0, ctx_restore_req, ctx_save_req}, 32'd2);
    repeat (waitc) @(negedge clk);
    popped_cc = cc;
    ctx_ack = 1;
    @(negedge clk);
    ctx_ack = 0;
    popped_cc = 8'h00;
    chk("R9", {28'd0, svc_valid, lvl_load, lvl_new}, {28'd0, 1'b0, 1'b1, el});
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; irq_req = '0; irq_prio = {NS{2'b10}}; tli_req = 0; trap_req = 0;
    cpu_lvl = 2'b10; instr_done = 0; iret_req = 0; ctx_ack = 0; popped_cc = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {12'd0, svc_valid, lvl_load, lvl_new, svc_addr}, {12'd0, 1'b1, 1'b1, 2'b11, 16'hFFFE});
    chk("R1", {30'd0, ctx_save_req, ctx_restore_req}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {31'd0, svc_valid}, 32'd0);

    // R2 no boundary, no entry; stray ack ignored
    cur_tag = "R2";
    irq_req[4] = 1; set_prio(4, 2'b01);
    repeat (2) @(negedge clk);
    chk("R2", {31'd0, ctx_save_req}, 32'd0);
    ctx_ack = 1;
    @(negedge clk);
    ctx_ack = 0;
    @(negedge clk);
    chk("R2", {30'd0, svc_valid, lvl_load}, 32'd0);

    // R7 basic entry with delayed ack; source 4 level 1
    do_entry(2, 16'hFFF0, 2'b01, "R7");
    do_entry(0, 16'hFFF0, 2'b01, "R7");

    // R4 / R10 highest level wins
    clear_reqs();
    irq_req[1] = 1; set_prio(1, 2'b01);
    irq_req[2] = 1; set_prio(2, 2'b00);
    irq_req[5] = 1; set_prio(5, 2'b11);
    do_entry(1, 16'hFFEE, 2'b11, "R10");

    // R4 equal levels: lowest index
    clear_reqs();
    irq_req[7] = 1; set_prio(7, 2'b00);
    irq_req[3] = 1; set_prio(3, 2'b00);
    do_entry(1, 16'hFFF2, 2'b00, "R4");
    clear_reqs();
    irq_req[12] = 1; set_prio(12, 2'b01);
    do_entry(0, 16'hFFE0, 2'b01, "R4");

    // R3 strictly above: level 2 current blocks level 2 source
    cur_tag = "R3";
    clear_reqs(); cpu_lvl = 2'b00;
    irq_req[3] = 1; set_prio(3, 2'b00);
    instr_done = 1;
    @(negedge clk);
    instr_done = 0;
    chk("R3", {31'd0, ctx_save_req}, 32'd0);
    irq_req[9] = 1; set_prio(9, 2'b11);
    do_entry(1, 16'hFFE6, 2'b11, "R10");

    // R6 tli masked at level 3, R5 trap still taken
    cpu_lvl = 2'b11; clear_reqs();
    irq_req[0] = 1; set_prio(0, 2'b11);
    tli_req = 1; cur_tag = "R6";
    instr_done = 1;
    @(negedge clk);
    instr_done = 0;
    chk("R6", {31'd0, ctx_save_req}, 32'd0);
    trap_req = 1;
    do_entry(1, 16'hFFFC, 2'b11, "R5");
    trap_req = 0;

    // R6 tli beats a level 3 source
    cpu_lvl = 2'b01;
    do_entry(0, 16'hFFFA, 2'b11, "R6");

    // R8 changes during handshake do not alter the grant
    cur_tag = "R8";
    clear_reqs(); cpu_lvl = 2'b10;
    irq_req[6] = 1; set_prio(6, 2'b01);
    instr_done = 1;
    @(negedge clk);
    instr_done = 0;
    trap_req = 1; irq_req[2] = 1; set_prio(2, 2'b11); cpu_lvl = 2'b11;
    @(negedge clk);
    ctx_ack = 1;
    @(negedge clk);
    ctx_ack = 0; trap_req = 0; clear_reqs();
    chk("R8", {14'd0, lvl_new, svc_addr}, {14'd0, 2'b01, 16'hFFEC});
    @(negedge clk);

    // R9 returns
    cpu_lvl = 2'b10;
    do_return(8'h20, 1, 2'b10);
    do_return(8'hD7, 0, 2'b00);
    do_return(8'h08, 3, 2'b01);
    // R9 iret beats instr_done at the same edge
    irq_req[4] = 1; set_prio(4, 2'b11);
    instr_done = 1; iret_req = 1;
    @(negedge clk);
    instr_done = 0; iret_req = 0;
    chk("R9", {30'd0, ctx_restore_req, ctx_save_req}, 32'd2);
    popped_cc = 8'h28; ctx_ack = 1;
    @(negedge clk);
    ctx_ack = 0;
    chk("R9", {30'd0, lvl_new}, {30'd0, 2'b11});
    @(negedge clk);
    clear_reqs();

    // random phase, compared against the model every cycle
    cur_tag = "RND";
    for (int k = 0; k < 4000; k++) begin
      irq_req    = NS'($urandom);
      irq_prio   = (2*NS)'($urandom);
      cpu_lvl    = 2'($urandom);
      instr_done = ($urandom % 3) == 0;
      trap_req   = ($urandom % 16) == 0;
      tli_req    = ($urandom % 8) == 0;
      iret_req   = ($urandom % 10) == 0;
      ctx_ack    = ($urandom % 2) == 0;
      popped_cc  = 8'($urandom);
      @(negedge clk);
    end
    report();
  end

endmodule